// File: doc/BRIEF.md
# Serial EEPROM Node Address Loader

This block runs once after reset and fetches a 48-bit node address from a three-wire serial EEPROM. It drives chip select, serial clock and data toward the memory and samples the memory's data output. It reads the byte at location 0 and compares it with a fixed marker (0xA5). Only on a match does it read the six address bytes that follow and present them as a 48-bit address, together with a 64-bit form of that address.

If the marker does not match, the block raises an error flag, leaves the address outputs at zero and stops. Once it has finished, with either outcome, the bus stays idle and the outputs hold until the next reset. The serial clock half-period and the minimum deselect gap are counted in system clock cycles.

Top module: `eui_boot_loader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ee_cs` and `ee_sclk` are low, `addr_valid` and `addr_error` are low, and `addr48` is zero.
- R2: Each read sends 10 bits on `ee_mosi`, most significant first: a start bit 1, the opcode bits 1 then 0, and a 7-bit location. Each bit is set while `ee_sclk` is low and is held across the `ee_sclk` rising edge. One read has exactly 18 rising edges of `ee_sclk`.
- R3: After the tenth rising edge the memory returns a dummy zero, which is skipped. The 8 data bits, most significant first, are sampled from `ee_miso` at the end of the high phase of rising edges 11 to 18.
- R4: `ee_cs` stays low for at least `DESEL_CYC` system cycles before every read, including the first one. `ee_sclk` is never high while `ee_cs` is low.
- R5: The first read is of location 0. If the returned byte is not 0xA5, `addr_error` rises, `addr_valid` stays low and no further read is issued.
- R6: On a marker match, locations 1 to 6 are read in ascending order. The byte from location 1 lands in `addr48[47:40]` and the byte from location 6 lands in `addr48[7:0]`, and `addr_valid` then rises.
- R7: `addr64` equals `addr48[47:24]`, then 0xFFFE, then `addr48[23:0]`.
- R8: After `addr_valid` or `addr_error` rises, that flag stays high and `addr48` stays constant until reset. No further chip select activity follows.
- R9: `addr_valid` and `addr_error` are never high together, and `addr48` is zero whenever `addr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; starts a new load when released |
| ee_cs | output | 1 | Memory chip select, high active |
| ee_sclk | output | 1 | Serial clock to the memory |
| ee_mosi | output | 1 | Serial data toward the memory |
| ee_miso | input | 1 | Serial data from the memory |
| addr48 | output | 48 | Loaded node address, first byte in the top bits |
| addr64 | output | 64 | 64-bit form with 0xFFFE inserted in the middle |
| addr_valid | output | 1 | Address loaded and marker correct |
| addr_error | output | 1 | Marker missing; no address |

## Verification
Two decisions fall on the same completion pulse of the serial engine. The marker decision uses the byte from location 0. The capture of the final address byte uses the byte from location 6 together with the valid flag. A fault that mixes the two paths shows up when the stored contents hold 0xA5 at locations other than 0, or hold markers that differ from 0xA5 in a single bit (0xA4, 0x25, 0xE5). The bench provokes both cases by placing such values in its memory model. It then judges the flags, the number and order of reads it observed, and the exact 48-bit and 64-bit values against its own assembly of the stored bytes.

// File: rtl/eui_pkg.sv
package eui_pkg;
  typedef enum logic [2:0] {
    SR_IDLE,
    SR_GAP,
    SR_LO,
    SR_HI
  } ser_st_t;

  typedef enum logic [1:0] {
    SQ_KICK,
    SQ_WAIT,
    SQ_DONE
  } seq_st_t;

  localparam logic [1:0] RD_OPCODE = 2'b10;
endpackage

// File: rtl/eui_ser_rd.sv
module eui_ser_rd
  import eui_pkg::*;
#(
  parameter int HALF_CYC  = 4,
  parameter int DESEL_CYC = 6,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_done,
  output logic [7:0]        rd_data,
  output logic              ee_cs,
  output logic              ee_sclk,
  output logic              ee_mosi,
  input  logic              ee_miso
);
  localparam int CMD_W   = 3 + ADDR_W;
  localparam int TOT_CLK = CMD_W + 8;
  localparam int CNT_MAX = (HALF_CYC > DESEL_CYC) ? HALF_CYC : DESEL_CYC;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int IW      = $clog2(TOT_CLK + 1);

  ser_st_t          st;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    bit_idx;
  logic [CMD_W-1:0] cmd_sh;
  logic [7:0]       data_sh;

  assign ee_cs   = (st == SR_LO) || (st == SR_HI);
  assign ee_sclk = (st == SR_HI);
  assign ee_mosi = ee_cs && cmd_sh[CMD_W-1];
  assign rd_data = data_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SR_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
      cmd_sh  <= '0;
      data_sh <= '0;
      rd_done <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      unique case (st)
        SR_IDLE: if (rd_start) begin
          cmd_sh  <= {1'b1, RD_OPCODE, rd_addr};
          bit_idx <= '0;
          cnt     <= '0;
          st      <= SR_GAP;
        end
        SR_GAP: begin
          if (cnt == CW'(DESEL_CYC - 1)) begin
            cnt <= '0;
            st  <= SR_LO;
          end else cnt <= cnt + 1'b1;
        end
        SR_LO: begin
          if (cnt == CW'(HALF_CYC - 1)) begin
            cnt <= '0;
            st  <= SR_HI;
          end else cnt <= cnt + 1'b1;
        end
        SR_HI: begin
          if (cnt == CW'(HALF_CYC - 1)) begin
            cnt <= '0;
            if (bit_idx >= IW'(CMD_W)) data_sh <= {data_sh[6:0], ee_miso};
            cmd_sh <= {cmd_sh[CMD_W-2:0], 1'b0};
            if (bit_idx == IW'(TOT_CLK - 1)) begin
              rd_done <= 1'b1;
              st      <= SR_IDLE;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              st      <= SR_LO;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= SR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eui_seq.sv
module eui_seq
  import eui_pkg::*;
#(
  parameter int         ADDR_W  = 7,
  parameter int         N_BYTES = 6,
  parameter logic [7:0] MARKER  = 8'hA5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic                 rd_start,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_done,
  input  logic [7:0]           rd_data,
  output logic [N_BYTES*8-1:0] addr_out,
  output logic                 addr_valid,
  output logic                 addr_error
);
  localparam int AW = N_BYTES * 8;
  localparam int XW = $clog2(N_BYTES + 1);

  seq_st_t       st;
  logic [XW-1:0] idx;
  logic [AW-1:0] acc;

  assign rd_start = (st == SQ_KICK);
  assign rd_addr  = ADDR_W'(idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SQ_KICK;
      idx        <= '0;
      acc        <= '0;
      addr_out   <= '0;
      addr_valid <= 1'b0;
      addr_error <= 1'b0;
    end else begin
      unique case (st)
        SQ_KICK: st <= SQ_WAIT;
        SQ_WAIT: if (rd_done) begin
          if (idx == '0) begin
            if (rd_data != MARKER) begin
              addr_error <= 1'b1;
              st         <= SQ_DONE;
            end else begin
              idx <= idx + 1'b1;
              st  <= SQ_KICK;
            end
          end else if (idx == XW'(N_BYTES)) begin
            addr_out   <= {acc[AW-9:0], rd_data};
            addr_valid <= 1'b1;
            st         <= SQ_DONE;
          end else begin
            acc <= {acc[AW-9:0], rd_data};
            idx <= idx + 1'b1;
            st  <= SQ_KICK;
          end
        end
        SQ_DONE: st <= SQ_DONE;
        default: st <= SQ_DONE;
      endcase
    end
  end
endmodule

// File: rtl/eui_boot_loader.sv
module eui_boot_loader #(
  parameter int         HALF_CYC  = 4,
  parameter int         DESEL_CYC = 6,
  parameter int         ADDR_W    = 7,
  parameter logic [7:0] MARKER    = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        ee_cs,
  output logic        ee_sclk,
  output logic        ee_mosi,
  input  logic        ee_miso,
  output logic [47:0] addr48,
  output logic [63:0] addr64,
  output logic        addr_valid,
  output logic        addr_error
);
  localparam int          N_BYTES = 6;
  localparam logic [15:0] FILL64  = 16'hFFFE;

  logic              rd_start;
  logic              rd_done;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;

  eui_seq #(.ADDR_W(ADDR_W), .N_BYTES(N_BYTES), .MARKER(MARKER)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data),
    .addr_out(addr48), .addr_valid(addr_valid), .addr_error(addr_error)
  );

  eui_ser_rd #(.HALF_CYC(HALF_CYC), .DESEL_CYC(DESEL_CYC), .ADDR_W(ADDR_W)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .rd_start(rd_start), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data),
    .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_mosi(ee_mosi), .ee_miso(ee_miso)
  );

  assign addr64 = {addr48[47:24], FILL64, addr48[23:0]};
endmodule

// File: rtl/eui_boot_chk.sv
module eui_boot_chk #(
  parameter int DESEL_CYC = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        ee_cs,
  input logic        ee_sclk,
  input logic [47:0] addr48,
  input logic        addr_valid,
  input logic        addr_error
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (ee_cs) low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
  end

  // R4
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sclk);

  // R4
  desel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> (low_cnt >= 16'(DESEL_CYC)));

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && addr_error));

  // R9
  addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> (addr48 == '0));

  // R8
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> (addr_valid && $stable(addr48)));

  // R8
  error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_error |=> addr_error);

  // R8
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid || addr_error) |-> !ee_cs);
endmodule

bind eui_boot_loader eui_boot_chk #(.DESEL_CYC(DESEL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sclk(ee_sclk),
  .addr48(addr48), .addr_valid(addr_valid), .addr_error(addr_error)
);

// File: tb/tb_eui_boot_loader.sv
`timescale 1ns/1ps
module tb_eui_boot_loader;
  localparam int HALF_CYC  = 4;
  localparam int DESEL_CYC = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ee_cs, ee_sclk, ee_mosi;
  logic        ee_miso = 1'b0;
  logic [47:0] addr48;
  logic [63:0] addr64;
  logic        addr_valid, addr_error;

  eui_boot_loader #(.HALF_CYC(HALF_CYC), .DESEL_CYC(DESEL_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sclk(ee_sclk),
    .ee_mosi(ee_mosi), .ee_miso(ee_miso), .addr48(addr48), .addr64(addr64),
    .addr_valid(addr_valid), .addr_error(addr_error)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // memory model
  logic [7:0] mem [0:127];
  int         m_bits;
  logic [8:0] m_cmd;
  logic [6:0] m_addr;
  int         rd_cnt;
  int         bad_op;
  int         edge_cnt;
  int         bad_edges;
  logic [6:0] rd_log [0:15];

  always @(posedge ee_sclk or negedge ee_cs) begin
    if (!ee_cs) begin
      if (m_bits != 0 && edge_cnt != 18) bad_edges = bad_edges + 1;
      m_bits = 0;
      edge_cnt = 0;
      ee_miso <= 1'b0;
    end else begin
      edge_cnt = edge_cnt + 1;
      if (m_bits == 0) begin
        if (ee_mosi) begin
          m_bits = 1;
          m_cmd  = '0;
        end
      end else if (m_bits < 10) begin
        m_cmd  = {m_cmd[7:0], ee_mosi};
        m_bits = m_bits + 1;
        if (m_bits == 10) begin
          if (m_cmd[8:7] != 2'b10) bad_op = bad_op + 1;
          m_addr = m_cmd[6:0];
          if (rd_cnt < 16) rd_log[rd_cnt] = m_addr;
          rd_cnt = rd_cnt + 1;
          ee_miso <= 1'b0;
        end
      end else if (m_bits < 18) begin
        ee_miso <= mem[m_addr][17 - m_bits];
        m_bits = m_bits + 1;
      end
    end
  end

  // protocol monitor
  int low_run, min_gap, sclk_bad;
  always @(negedge clk) begin
    if (!rst_n) low_run = 0;
    else if (!ee_cs) begin
      low_run = low_run + 1;
      if (ee_sclk) sclk_bad = sclk_bad + 1;
    end else begin
      if (low_run != 0 && low_run < min_gap) min_gap = low_run;
      low_run = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [47:0] exp48();
    logic [47:0] a = '0;
    for (int i = 1; i <= 6; i++) a = {a[39:0], mem[i]};
    return a;
  endfunction

  function automatic logic [63:0] exp64(input logic [47:0] a);
    return {a[47:24], 16'hFFFE, a[23:0]};
  endfunction

  task automatic run_trial(input logic [7:0] marker);
    bit          good;
    bit          seq_ok;
    logic [47:0] e48;
    logic [47:0] snap;
    int          snap_rd;
    int          waited;
    mem[0] = marker;
    good = (marker == 8'hA5);
    e48 = exp48();
    rd_cnt = 0; bad_op = 0; bad_edges = 0; sclk_bad = 0; min_gap = 1000000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!ee_cs && !ee_sclk && !addr_valid && !addr_error && addr48 == '0,
        "R1", "reset outputs", {ee_cs, ee_sclk, addr_valid, addr_error}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 first cycle after release
    chk(!ee_cs && !addr_valid && !addr_error, "R1", "after release",
        {ee_cs, addr_valid, addr_error}, 0);
    waited = 0;
    while (!addr_valid && !addr_error && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk(waited < 5000, "R5", "load finished", waited, 5000);
    // R5 R6 flags
    chk(addr_valid == good && addr_error == !good, "R5 R6", "flags",
        {addr_valid, addr_error}, {good, !good});
    // R9
    chk(!(addr_valid && addr_error), "R9", "flags exclusive",
        {addr_valid, addr_error}, 0);
    if (good) begin
      // R3 R6 byte order and bit order
      chk(addr48 == e48, "R3 R6", "addr48", addr48, e48);
      // R7
      chk(addr64 == exp64(e48), "R7", "addr64", addr64, exp64(e48));
      seq_ok = (rd_cnt == 7);
      for (int i = 0; i < 7; i++) if (rd_log[i] != 7'(i)) seq_ok = 0;
      chk(seq_ok, "R6", "read sequence count", rd_cnt, 7);
    end else begin
      chk(rd_cnt == 1 && rd_log[0] == 7'd0, "R5", "single read of location 0",
          rd_cnt, 1);
      // R9
      chk(addr48 == '0, "R9", "addr48 zero on error", addr48, 0);
    end
    // R2
    chk(bad_op == 0, "R2", "opcode bits", bad_op, 0);
    chk(bad_edges == 0, "R2", "18 clocks per read", bad_edges, 0);
    // R4
    chk(min_gap >= DESEL_CYC, "R4", "deselect gap", min_gap, DESEL_CYC);
    chk(sclk_bad == 0, "R4", "sclk low while deselected", sclk_bad, 0);
    snap = addr48; snap_rd = rd_cnt;
    repeat (200) @(negedge clk);
    // R8
    chk(addr48 == snap && addr_valid == good && addr_error == !good &&
        rd_cnt == snap_rd && !ee_cs, "R8", "hold after load",
        {addr48, addr_valid, addr_error}, {snap, good, !good});
  endtask

  initial begin
    logic [7:0] bads [0:5];
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
    rd_cnt = 0; bad_op = 0; bad_edges = 0; sclk_bad = 0; min_gap = 1000000;
    m_bits = 0; edge_cnt = 0;
    bads[0] = 8'hA4; bads[1] = 8'h25; bads[2] = 8'hE5;
    bads[3] = 8'h00; bads[4] = 8'hFF; bads[5] = 8'h5A;
    // directed: example address
    mem[1] = 8'h00; mem[2] = 8'h04; mem[3] = 8'hA3;
    mem[4] = 8'h12; mem[5] = 8'h34; mem[6] = 8'h56;
    run_trial(8'hA5);
    // directed: address bytes equal to marker
    for (int i = 1; i <= 6; i++) mem[i] = 8'hA5;
    run_trial(8'hA5);
    // directed: all ones, all zeros
    for (int i = 1; i <= 6; i++) mem[i] = 8'hFF;
    run_trial(8'hA5);
    for (int i = 1; i <= 6; i++) mem[i] = 8'h00;
    run_trial(8'hA5);
    // directed: near-miss markers with 0xA5 elsewhere
    for (int k = 0; k < 6; k++) begin
      for (int i = 1; i <= 6; i++) mem[i] = (i == 6) ? 8'hA5 : 8'($urandom);
      run_trial(bads[k]);
    end
    // random
    for (int t = 0; t < 10; t++) begin
      logic [7:0] mk;
      for (int i = 1; i <= 6; i++) mem[i] = 8'($urandom);
      mk = ($urandom % 3 == 0) ? 8'($urandom) : 8'hA5;
      run_trial(mk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule